// File: doc/BRIEF.md
# Shared-Medium Frame Transmit Sequencer

This block puts one frame onto a half-duplex medium shared by several stations, one bit per clock. After a start strobe it waits until carrier sense is low and the medium has been quiet for a full inter-frame gap. It then sends the frame bits in index order, taking each bit from an external source that it addresses through a bit index. It watches collision detect on every transmitted bit. A collision replaces the rest of the frame with a fixed-length jam burst, and a randomly drawn backoff delay follows before the block tries the frame again.

A counter tracks the attempts. When the count after a jam goes above the configured limit, the block gives up and reports excessive collisions. A frame that goes out to its last bit with no collision is reported as a success. The backoff delay is a whole number of slot times. The number of slots comes from a linear-feedback shift register that is seeded at each start, and the range it may take doubles with each collision up to a cap. CRC generation, frame storage and line coding belong to the surrounding logic.

Top module: `csma_tx_ctrl`

## Requirements
- R1: `start_i` is accepted only while the block is idle. Acceptance clears the attempt count and both status flags. A start seen while a frame is in progress has no effect: the bit index keeps counting without a restart.
- R2: While carrier sense is high and the block is waiting to send, `tx_en_o` stays low.
- R3: `tx_en_o` rises only after `GAP_BITS` consecutive cycles in which neither the block transmitted nor carrier sense was high. A gap that was already met lets the first bit out in the second cycle after the start is sampled. A gap cut short by carrier, or by the block's own frame or jam, must be waited out in full.
- R4: A frame goes out one bit per clock with `tx_en_o` high. `bit_index_o` steps 0, 1, ... up to frame length minus one, and `tx_bit_o` equals `frame_bit_i` in each of those cycles. Every retry restarts at index 0. The frame length must be at least 1.
- R5: If collision detect is high in a frame-bit cycle (the last bit included), the next cycle starts a jam of exactly `JAM_BITS` cycles. During the jam `tx_en_o` stays high and `tx_bit_o` alternates 1, 0, 1, ... starting with 1. Collision detect is ignored during the jam.
- R6: Each jam adds one to the attempt count. When the count goes above `ATTEMPT_LIMIT`, the block ends in failure with no backoff, so a medium that collides on every try sees `ATTEMPT_LIMIT`+1 jam bursts.
- R7: After the n-th jam, the idle time before the next transmission is at least `GAP_BITS` cycles. It is at most the larger of `GAP_BITS` and (2^min(n,`BACKOFF_CAP`) − 1)·`SLOT_BITS` + 2 cycles, provided carrier stays low.
- R8: In the cycle after the final frame bit, `tx_en_o` is low, `done_o` is high for that single cycle and `ok_o` is high. A failure pulses `done_o` in the same way, in the cycle after the last jam bit.
- R9: `ok_o` and `excess_o` are never high together, and each holds its value until the next accepted start.
- R10: After reset, `tx_en_o`, `tx_bit_o`, `done_o`, `ok_o` and `excess_o` are low and the gap counts as already met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one frame |
| frame_len_i | input | LEN_W | Frame length in bits, sampled with the start |
| frame_bit_i | input | 1 | Frame bit at `bit_index_o`, returned in the same cycle |
| bit_index_o | output | LEN_W | Index of the frame bit being sent |
| carrier_i | input | 1 | Another station is using the medium |
| collision_i | input | 1 | Collision detected on the medium |
| seed_i | input | LFSR_W | Seed for the backoff generator, loaded with the start |
| tx_bit_o | output | 1 | Serial bit driven onto the medium |
| tx_en_o | output | 1 | Transmitter enabled (frame or jam) |
| done_o | output | 1 | One-cycle pulse when the request ends |
| ok_o | output | 1 | Last request ended with the frame sent |
| excess_o | output | 1 | Last request ended after too many collisions |

## Verification
The assertions assume that `frame_bit_i` is a same-cycle function of `bit_index_o` and that `frame_len_i` is nonzero when a start is accepted. They also assume that collision detect is meaningful only while the block transmits. The bench drives every frame bit from a fixed table indexed by `bit_index_o` and starts only frames of one or more bits. It raises collision detect either at one chosen index of the first attempt or in every transmit cycle. Carrier stays low during backoff, so the timing bound of R7 holds.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEFER,
      ST_SEND,
      ST_JAM,
      ST_BACKOFF
   } tx_state_e;

endpackage

// File: rtl/csma_gap_timer.sv
module csma_gap_timer #(
   parameter int unsigned GAP_BITS = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic medium_busy_i,
   output logic gap_ok_o
);
   localparam int unsigned CNT_W = $clog2(GAP_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_BITS - 1);

   initial begin
      if (GAP_BITS < 2) $error("csma_gap_timer: GAP_BITS must be at least 2");
   end

   logic [CNT_W-1:0] quiet_q;

   // Counts quiet cycles since the medium was last busy, saturating at the gap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= CNT_LAST;
      end else if (medium_busy_i) begin
         quiet_q <= '0;
      end else if (quiet_q != CNT_LAST) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   assign gap_ok_o = (quiet_q == CNT_LAST);

   // R3: any busy cycle restarts the full gap
   p_busy_restarts_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      medium_busy_i |=> !gap_ok_o);

endmodule

// File: rtl/csma_backoff.sv
module csma_backoff #(
   parameter int unsigned SLOT_BITS   = 512,
   parameter int unsigned BACKOFF_CAP = 10,
   parameter int unsigned ATT_W       = 5,
   parameter int unsigned LFSR_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load_i,
   input  logic [LFSR_W-1:0] seed_i,
   input  logic              draw_i,
   input  logic [ATT_W-1:0]  attempts_i,
   output logic              expired_o
);
   localparam int unsigned SUB_W = $clog2(SLOT_BITS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_BITS - 1);

   initial begin
      if (SLOT_BITS < 2) $error("csma_backoff: SLOT_BITS must be at least 2");
      if (BACKOFF_CAP > LFSR_W) $error("csma_backoff: BACKOFF_CAP exceeds LFSR_W");
      if (LFSR_W != 16 && LFSR_W != 32) $error("csma_backoff: LFSR_W must be 16 or 32");
   end

   logic [LFSR_W-1:0]      lfsr_q;
   logic [LFSR_W-1:0]      lfsr_next;
   logic [BACKOFF_CAP-1:0] window;
   logic [BACKOFF_CAP-1:0] slots_q;
   logic [SUB_W-1:0]       sub_q;

   // Galois shift register; the polynomial follows the chosen width
   generate
      if (LFSR_W == 32) begin : g_lfsr32
         assign lfsr_next = {1'b0, lfsr_q[LFSR_W-1:1]}
                            ^ (lfsr_q[0] ? LFSR_W'(32'h8020_0003) : '0);
      end else begin : g_lfsr16
         assign lfsr_next = {1'b0, lfsr_q[LFSR_W-1:1]}
                            ^ (lfsr_q[0] ? LFSR_W'(16'hB400) : '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= LFSR_W'(1);
      end else if (seed_load_i) begin
         lfsr_q <= seed_i | LFSR_W'(seed_i == '0);
      end else begin
         lfsr_q <= lfsr_next;
      end
   end

   // Window bit b is open once more than b collisions occurred (caps by width)
   always_comb begin
      for (int b = 0; b < int'(BACKOFF_CAP); b++) begin
         window[b] = (int'(attempts_i) > b);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q <= '0;
         sub_q   <= '0;
      end else if (draw_i) begin
         slots_q <= lfsr_q[BACKOFF_CAP-1:0] & window;
         sub_q   <= '0;
      end else if (slots_q != '0) begin
         if (sub_q == SUB_LAST) begin
            sub_q   <= '0;
            slots_q <= slots_q - 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   assign expired_o = (slots_q == '0);

   // R7: a drawn slot count never falls outside the window for this attempt
   p_draw_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      draw_i |=> ((slots_q & ~$past(window)) == '0));

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
   import csma_tx_pkg::*;
#(
   parameter int unsigned LEN_W         = 11,
   parameter int unsigned GAP_BITS      = 96,
   parameter int unsigned SLOT_BITS     = 512,
   parameter int unsigned JAM_BITS      = 32,
   parameter int unsigned ATTEMPT_LIMIT = 16,
   parameter int unsigned BACKOFF_CAP   = 10,
   parameter int unsigned LFSR_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  frame_len_i,
   input  logic              frame_bit_i,
   output logic [LEN_W-1:0]  bit_index_o,
   input  logic              carrier_i,
   input  logic              collision_i,
   input  logic [LFSR_W-1:0] seed_i,
   output logic              tx_bit_o,
   output logic              tx_en_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              excess_o
);
   localparam int unsigned ATT_W = $clog2(ATTEMPT_LIMIT + 2);
   localparam int unsigned JAM_W = $clog2(JAM_BITS);
   localparam logic [JAM_W-1:0] JAM_LAST = JAM_W'(JAM_BITS - 1);
   localparam logic [ATT_W-1:0] ATT_MAX  = ATT_W'(ATTEMPT_LIMIT);

   initial begin
      if (JAM_BITS < 2) $error("csma_tx_ctrl: JAM_BITS must be at least 2");
      if (ATTEMPT_LIMIT < 1) $error("csma_tx_ctrl: ATTEMPT_LIMIT must be at least 1");
      if (LEN_W < 1) $error("csma_tx_ctrl: LEN_W must be at least 1");
   end

   tx_state_e        state_q;
   logic [ATT_W-1:0] attempts_q;
   logic [LEN_W-1:0] bit_cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [JAM_W-1:0] jam_cnt_q;
   logic             done_q;
   logic             ok_q;
   logic             excess_q;

   logic             gap_ok;
   logic             bo_expired;
   logic             seed_load;
   logic             bo_draw;
   logic             jam_last;
   logic             last_bit;
   logic [ATT_W-1:0] attempts_inc;
   logic             att_over;

   assign seed_load    = (state_q == ST_IDLE) && start_i;
   assign jam_last     = (state_q == ST_JAM) && (jam_cnt_q == JAM_LAST);
   assign last_bit     = (bit_cnt_q == len_q - 1'b1);
   assign attempts_inc = attempts_q + 1'b1;
   assign att_over     = (attempts_inc > ATT_MAX);
   assign bo_draw      = jam_last && !att_over;

   csma_gap_timer #(
      .GAP_BITS (GAP_BITS)
   ) u_gap (
      .clk           (clk),
      .rst_n         (rst_n),
      .medium_busy_i (tx_en_o | carrier_i),
      .gap_ok_o      (gap_ok)
   );

   csma_backoff #(
      .SLOT_BITS   (SLOT_BITS),
      .BACKOFF_CAP (BACKOFF_CAP),
      .ATT_W       (ATT_W),
      .LFSR_W      (LFSR_W)
   ) u_backoff (
      .clk         (clk),
      .rst_n       (rst_n),
      .seed_load_i (seed_load),
      .seed_i      (seed_i),
      .draw_i      (bo_draw),
      .attempts_i  (attempts_inc),
      .expired_o   (bo_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         attempts_q <= '0;
         bit_cnt_q  <= '0;
         len_q      <= '0;
         jam_cnt_q  <= '0;
         done_q     <= 1'b0;
         ok_q       <= 1'b0;
         excess_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  len_q      <= frame_len_i;
                  attempts_q <= '0;
                  ok_q       <= 1'b0;
                  excess_q   <= 1'b0;
                  state_q    <= ST_DEFER;
               end
            end
            ST_DEFER: begin
               if (!carrier_i && gap_ok) begin
                  bit_cnt_q <= '0;
                  state_q   <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (collision_i) begin
                  jam_cnt_q <= '0;
                  state_q   <= ST_JAM;
               end else if (last_bit) begin
                  done_q  <= 1'b1;
                  ok_q    <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end
            end
            ST_JAM: begin
               if (jam_cnt_q == JAM_LAST) begin
                  attempts_q <= attempts_inc;
                  if (att_over) begin
                     done_q   <= 1'b1;
                     excess_q <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else begin
                     state_q <= ST_BACKOFF;
                  end
               end else begin
                  jam_cnt_q <= jam_cnt_q + 1'b1;
               end
            end
            ST_BACKOFF: begin
               if (bo_expired) state_q <= ST_DEFER;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_en_o  = (state_q == ST_SEND) || (state_q == ST_JAM);
      tx_bit_o = 1'b0;
      if (state_q == ST_SEND) tx_bit_o = frame_bit_i;
      else if (state_q == ST_JAM) tx_bit_o = ~jam_cnt_q[0];
   end

   assign bit_index_o = bit_cnt_q;
   assign done_o      = done_q;
   assign ok_o        = ok_q;
   assign excess_o    = excess_q;

   // R1: an accepted start leaves no stale status and no stale attempts
   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> (attempts_q == '0 && !ok_o && !excess_o));

   // R2: no transmission begins while carrier is present
   p_defer_on_carrier_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEFER && carrier_i) |=> !tx_en_o);

   // R3: transmission starts only when the gap timer reported a full gap
   p_gap_before_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en_o) |-> $past(gap_ok));

   // R5: a collision during frame data turns into a jam that starts with 1
   p_collision_jams_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && collision_i) |=> (tx_en_o && tx_bit_o));

   // R6: the attempt count never runs past the limit plus one
   p_attempt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      attempts_q <= ATT_W'(ATTEMPT_LIMIT + 1));

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: the outcome flags are exclusive
   p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && excess_o));

endmodule

// File: tb/csma_tx_ctrl_tb.sv
module csma_tx_ctrl_tb;
   localparam int IFG   = 12;
   localparam int SLOT  = 8;
   localparam int JAM   = 32;
   localparam int LIMIT = 16;
   localparam int CAP   = 10;
   localparam int LW    = 8;
   localparam int RW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [LW-1:0] frame_len_i = '0;
   logic          frame_bit_i;
   logic [LW-1:0] bit_index_o;
   logic          carrier_i = 1'b0;
   logic          collision_i;
   logic [RW-1:0] seed_i = 16'h5A3C;
   logic          tx_bit_o, tx_en_o, done_o, ok_o, excess_o;

   logic [255:0]  pattern;
   logic          coll_all = 1'b0;
   logic          coll_arm = 1'b0;
   int            coll_idx = 0;
   int            checks = 0;
   int            errors = 0;
   int            cycles = 0;
   bit            reported = 1'b0;

   always #2.5 clk = ~clk;

   assign frame_bit_i = pattern[bit_index_o];
   assign collision_i = coll_all ? tx_en_o
                      : (coll_arm && tx_en_o && (int'(bit_index_o) == coll_idx));

   csma_tx_ctrl #(
      .LEN_W (LW), .GAP_BITS (IFG), .SLOT_BITS (SLOT), .JAM_BITS (JAM),
      .ATTEMPT_LIMIT (LIMIT), .BACKOFF_CAP (CAP), .LFSR_W (RW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .frame_len_i (frame_len_i),
      .frame_bit_i (frame_bit_i), .bit_index_o (bit_index_o), .carrier_i (carrier_i),
      .collision_i (collision_i), .seed_i (seed_i), .tx_bit_o (tx_bit_o),
      .tx_en_o (tx_en_o), .done_o (done_o), .ok_o (ok_o), .excess_o (excess_o)
   );

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         summary();
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit cond, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int gap_hi(input int n);
      int k = (n < CAP) ? n : CAP;
      int hi = ((1 << k) - 1) * SLOT + 2;
      return (hi < IFG) ? IFG : hi;
   endfunction

   // Follows one request from its first transmit cycle until done_o
   task automatic watch(input int poke, output int bursts, output int sent);
      int  jam_left = 0;
      bit  pend = 1'b0;
      bit  prev_en = 1'b0;
      int  idle = 0;
      int  guard = 0;
      bursts = 0;
      sent = 0;
      while (!done_o && guard < 140000) begin
         guard++;
         start_i = 1'b0;
         if (pend) begin
            coll_arm = 1'b0;
            jam_left = JAM;
            pend = 1'b0;
         end
         if (tx_en_o && !prev_en) begin
            sent = 0;
            if (bursts > 0)
               chk(idle >= IFG && idle <= gap_hi(bursts), "R7", "idle after jam",
                   idle, gap_hi(bursts));
         end
         if (tx_en_o) begin
            if (jam_left > 0) begin
               chk(tx_bit_o == (((JAM - jam_left) % 2) == 0), "R5", "jam bit",
                   tx_bit_o, ((JAM - jam_left) % 2) == 0);
               jam_left--;
               if (jam_left == 0) bursts++;
            end else begin
               chk(int'(bit_index_o) == sent, "R4", "bit index", bit_index_o, sent);
               chk(tx_bit_o == pattern[sent], "R4", "frame bit", tx_bit_o, pattern[sent]);
               if (collision_i) pend = 1'b1;
               else if (sent == poke) start_i = 1'b1;
               sent++;
            end
            idle = 0;
         end else begin
            if (jam_left > 0) begin
               chk(1'b0, "R5", "jam cut short", jam_left, 0);
               jam_left = 0;
            end
            idle++;
         end
         prev_en = tx_en_o;
         step();
      end
      start_i = 1'b0;
   endtask

   task automatic start_frame(input int len);
      frame_len_i = LW'(len);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
   endtask

   task automatic t_reset();
      chk(!tx_en_o && !tx_bit_o, "R10", "tx idle at reset", tx_en_o, 0);
      chk(!done_o && !ok_o && !excess_o, "R10", "status low at reset",
          {done_o, ok_o, excess_o}, 0);
   endtask

   // Clean frame with a spurious start mid-frame
   task automatic t_clean(input int len);
      int b, s;
      start_frame(len);
      chk(!tx_en_o && !ok_o, "R1", "start accepted, status cleared", ok_o, 0);
      step();
      chk(tx_en_o, "R3", "first bit two cycles after start", tx_en_o, 1);
      watch(3, b, s);
      chk(s == len, "R1", "mid-frame start ignored, bit count", s, len);
      chk(done_o && ok_o && !excess_o && !tx_en_o, "R8", "success at end",
          {done_o, ok_o, excess_o, tx_en_o}, 4'b1100);
      step();
      chk(!done_o, "R8", "done is one cycle", done_o, 0);
      step();
      step();
      chk(ok_o && !excess_o, "R9", "ok holds after done", ok_o, 1);
   endtask

   // Back-to-back frames must leave exactly one gap
   task automatic t_back_to_back();
      int b, s, idle;
      start_frame(10);
      step();
      watch(-1, b, s);
      idle = 1;
      start_i = 1'b1;
      frame_len_i = LW'(7);
      step();
      start_i = 1'b0;
      while (!tx_en_o && idle < 1000) begin
         idle++;
         step();
      end
      chk(idle == IFG, "R3", "gap after own frame", idle, IFG);
      watch(-1, b, s);
      chk(ok_o && s == 7, "R8", "second frame sent", s, 7);
   endtask

   task automatic t_defer();
      int b, s, idle;
      bit seen = 1'b0;
      carrier_i = 1'b1;
      start_frame(9);
      for (int i = 0; i < 30; i++) begin
         if (tx_en_o) seen = 1'b1;
         step();
      end
      chk(!seen, "R2", "no tx while carrier high", seen, 0);
      carrier_i = 1'b0;
      idle = 0;
      while (!tx_en_o && idle < 1000) begin
         idle++;
         step();
      end
      chk(idle == IFG, "R3", "full gap after carrier drops", idle, IFG);
      watch(-1, b, s);
      chk(ok_o && s == 9, "R8", "deferred frame sent", s, 9);
   endtask

   task automatic t_collision(input int len, input int idx);
      int b, s;
      coll_idx = idx;
      coll_arm = 1'b1;
      start_frame(len);
      watch(-1, b, s);
      chk(b == 1, "R5", "one jam burst", b, 1);
      chk(ok_o && !excess_o && s == len, "R4", "retry resent whole frame", s, len);
      chk(done_o, "R8", "done after retry", done_o, 1);
   endtask

   task automatic t_excess();
      int b, s;
      coll_all = 1'b1;
      start_frame(6);
      watch(-1, b, s);
      coll_all = 1'b0;
      chk(b == LIMIT + 1, "R6", "jam bursts before giving up", b, LIMIT + 1);
      chk(done_o && excess_o && !ok_o, "R6", "excess failure flags",
          {done_o, excess_o, ok_o}, 3'b110);
      step();
      step();
      chk(excess_o && !ok_o, "R9", "excess holds", excess_o, 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) pattern[i] = (((i * 7) + 3) % 5) < 2;
      #1;
      step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_clean(20);
      t_back_to_back();
      t_defer();
      t_collision(16, 5);
      t_collision(12, 11);
      t_excess();
      // R1: attempts restart from zero, so the first backoff window applies
      t_collision(14, 0);
      chk(!excess_o, "R9", "excess cleared by new start", excess_o, 0);
      summary();
      $finish;
   end

endmodule